// File: doc/BRIEF.md
# Management Serial Target with Byte-Register Extension

This block is the target side of a two-wire serial management link. A controller toggles a management clock and moves one bit per clock period over a shared data line. Each transaction begins with a run of ones and a two-bit start marker. A two-bit operation code, a 5-bit port address, a 5-bit register address, a two-bit turnaround and a 16-bit data word follow, most significant bit first. The standard read and write codes reach a small bank of 16-bit port registers, but only when the port address equals the configured one.

The operation code 00 is otherwise unused by the standard, and here it opens a second bank of byte-wide registers. The top bit of the port address selects read (1) or write (0), and its bit 3 is not decoded. The low three port-address bits followed by the five register-address bits form an 8-bit byte address. A byte read returns the byte in the low half of the data word with zeros above it. A byte write keeps only the low half of the word.

The block runs on a fast system clock. It re-times the management clock and data, and treats each rising edge of the management clock as one bit sample. Its own outputs change only in the system cycle after a sample, so they are settled well before the controller's next rising edge. A plain local port reads and writes both banks. When the serial link and the local port write the same entry in the same cycle, the serial write wins.

Top module: `mdio_mgmt_target`

## Requirements
- R1: A transaction is recognised only after at least 32 consecutive one bits followed by the start marker 0 then 1. If only 31 ones come before the marker, the target does not respond.
- R2: A start marker other than 0 then 1 abandons the transaction. The bits that follow are not decoded until a new run of 32 ones and a valid marker arrive.
- R3: For a read the target responds to, it leaves the line released during the first turnaround bit. It drives 0 during the second, then drives the 16 data bits MSB first, and releases the line after the last data bit. The outputs change only in the system cycle after a management clock rising edge.
- R4: Operation code 01 with the configured port address writes the 16 data bits into the port register chosen by the register address. Code 10 with the configured port address reads it back.
- R5: Standard codes with a different port address, and code 11, are ignored. The line stays released and no register changes.
- R6: Code 00 with port-address bit 4 equal to 1 reads the byte register and returns 0x00 in the upper eight data bits.
- R7: Code 00 with port-address bit 4 equal to 0 stores data bits 7:0 into the byte register. Data bits 15:8 are discarded.
- R8: Port-address bit 3 has no effect on a code 00 access.
- R9: Byte addresses above 0xC6 are ignored by code 00 accesses: a read leaves the line released and a write stores nothing. A local read of such an address returns 0. Address 0xC6 itself is a working register.
- R10: The byte address is {port address bits 2:0, register address bits 4:0}, with the port-address bits most significant.
- R11: The local port writes the selected entry on a write strobe. Its read data reflects the entry combinationally: 16 bits for the port bank (lcl_phy_sel=1) and {8'h00, byte} for the byte bank (lcl_phy_sel=0). A port-bank index at or beyond the bank size reads as 0.
- R12: After reset the data line is released and every register in both banks holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the management clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc | input | 1 | Management clock from the controller |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data value driven by the target |
| mdio_oe | output | 1 | Drive enable for the data line, high while the target drives |
| cfg_phy_addr | input | 5 | Port address this target answers to on standard codes |
| lcl_phy_sel | input | 1 | Local port bank select: 1 port bank, 0 byte bank |
| lcl_addr | input | 8 | Local port register index |
| lcl_wdata | input | 16 | Local port write data (low byte used for the byte bank) |
| lcl_we | input | 1 | Local port write strobe |
| lcl_rdata | output | 16 | Local port read data |

## Verification
A wrong phase or bit counter in the frame tracker shows up within the same transaction. The target drives during the wrong turnaround bit, shifts the data one place, or keeps the line driven into the idle bit after the frame. A bad decode of the operation code, the address-match or the byte-address concatenation lands a write in the wrong entry, which the local port shows immediately. It can also produce a read that answers when it should stay silent. Corrupted preamble counting is exposed by the 31-one and bad-marker transactions: the target either answers a frame it should ignore, or goes silent on the well-formed frame that follows.

// File: rtl/mdio_tgt_pkg.sv
package mdio_tgt_pkg;

  typedef enum logic [2:0] {
    PH_PREAMBLE,
    PH_START,
    PH_HEADER,
    PH_TURN,
    PH_DATA
  } phase_e;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_PHY_RD,
    ACT_PHY_WR,
    ACT_BYTE_RD,
    ACT_BYTE_WR
  } act_e;

  localparam logic [1:0] OPC_PHY_RD = 2'b10;
  localparam logic [1:0] OPC_PHY_WR = 2'b01;
  localparam logic [1:0] OPC_EXT    = 2'b00;

  localparam int HDR_BITS  = 12;
  localparam int DATA_BITS = 16;

  typedef struct packed {
    act_e       act;
    logic [7:0] addr;
  } access_t;

  // Header layout, oldest bit first: opcode(2) port(5) register(5)
  function automatic access_t decode_header(input logic [HDR_BITS-1:0] h,
                                            input logic [4:0]          own,
                                            input logic [7:0]          byte_last);
    access_t    r;
    logic [1:0] op;
    logic [4:0] pa;
    logic [4:0] ra;
    logic [7:0] baddr;
    op    = h[11:10];
    pa    = h[9:5];
    ra    = h[4:0];
    baddr = {pa[2:0], ra};
    r.act  = ACT_IDLE;
    r.addr = '0;
    if (op == OPC_PHY_RD && pa == own) begin
      r.act  = ACT_PHY_RD;
      r.addr = {3'b000, ra};
    end else if (op == OPC_PHY_WR && pa == own) begin
      r.act  = ACT_PHY_WR;
      r.addr = {3'b000, ra};
    end else if (op == OPC_EXT && baddr <= byte_last) begin
      r.addr = baddr;
      r.act  = pa[4] ? ACT_BYTE_RD : ACT_BYTE_WR;
    end
    return r;
  endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_pin,
  input  logic mdio_pin,
  output logic sample_stb,
  output logic sample_bit
);
  logic [STAGES-1:0] mdc_sh;
  logic [STAGES-1:0] dat_sh;
  logic              mdc_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_sh   <= '0;
      dat_sh   <= '1;
      mdc_last <= 1'b0;
    end else begin
      mdc_sh   <= {mdc_sh[STAGES-2:0], mdc_pin};
      dat_sh   <= {dat_sh[STAGES-2:0], mdio_pin};
      mdc_last <= mdc_sh[STAGES-1];
    end
  end

  // data chain has the same depth as the clock chain, so the bit is aligned
  assign sample_stb = mdc_sh[STAGES-1] & ~mdc_last;
  assign sample_bit = dat_sh[STAGES-1];
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_tgt_pkg::*;
#(
  parameter int         PRE_LEN   = 32,
  parameter logic [7:0] BYTE_LAST = 8'hC6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_stb,
  input  logic        bit_val,
  input  logic [4:0]  own_addr,
  input  logic [15:0] bus_rdata,
  output logic        bus_is_phy,
  output logic [7:0]  bus_addr,
  output logic        bus_we,
  output logic [15:0] bus_wdata,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int OW = $clog2(PRE_LEN + 1);
  localparam int CW = $clog2(DATA_BITS);
  localparam logic [OW-1:0] ONES_FULL = OW'(PRE_LEN);
  localparam logic [CW-1:0] HDR_END   = CW'(HDR_BITS - 1);
  localparam logic [CW-1:0] DATA_END  = CW'(DATA_BITS - 1);

  phase_e                phase;
  logic [OW-1:0]         ones;
  logic [CW-1:0]         cnt;
  logic [HDR_BITS-2:0]   hdr;
  logic [HDR_BITS-1:0]   hdr_next;
  access_t               acc;
  logic [DATA_BITS-1:0]  shreg;
  logic                  is_rd;
  logic                  is_wr;

  assign hdr_next = {hdr, bit_val};
  assign is_rd    = (acc.act == ACT_PHY_RD) || (acc.act == ACT_BYTE_RD);
  assign is_wr    = (acc.act == ACT_PHY_WR) || (acc.act == ACT_BYTE_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_PREAMBLE;
      ones    <= '0;
      cnt     <= '0;
      hdr     <= '0;
      acc     <= '{act: ACT_IDLE, addr: '0};
      shreg   <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      bus_we  <= 1'b0;
    end else begin
      bus_we <= 1'b0;
      if (bit_stb) begin
        unique case (phase)
          PH_PREAMBLE: begin
            if (bit_val) begin
              if (ones != ONES_FULL) ones <= ones + 1'b1;
            end else begin
              if (ones == ONES_FULL) phase <= PH_START;
              ones <= '0;
            end
          end
          PH_START: begin
            phase <= bit_val ? PH_HEADER : PH_PREAMBLE;
            cnt   <= '0;
          end
          PH_HEADER: begin
            hdr <= hdr_next[HDR_BITS-2:0];
            if (cnt == HDR_END) begin
              acc   <= decode_header(hdr_next, own_addr, BYTE_LAST);
              phase <= PH_TURN;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_TURN: begin
            if (cnt == '0) begin
              cnt <= 1;
              if (is_rd) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
                shreg   <= bus_rdata;
              end
            end else begin
              cnt   <= '0;
              phase <= PH_DATA;
              if (is_rd) begin
                mdio_o <= shreg[DATA_BITS-1];
                shreg  <= {shreg[DATA_BITS-2:0], 1'b0};
              end
            end
          end
          PH_DATA: begin
            if (cnt == DATA_END) begin
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b0;
              phase   <= PH_PREAMBLE;
              ones    <= '0;
              cnt     <= '0;
              if (is_wr) begin
                shreg  <= {shreg[DATA_BITS-2:0], bit_val};
                bus_we <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
              if (is_rd) begin
                mdio_o <= shreg[DATA_BITS-1];
                shreg  <= {shreg[DATA_BITS-2:0], 1'b0};
              end else begin
                shreg <= {shreg[DATA_BITS-2:0], bit_val};
              end
            end
          end
          default: phase <= PH_PREAMBLE;
        endcase
      end
    end
  end

  assign bus_is_phy = (acc.act == ACT_PHY_RD) || (acc.act == ACT_PHY_WR);
  assign bus_addr   = acc.addr;
  assign bus_wdata  = shreg;
endmodule

// File: rtl/mdio_reg_banks.sv
module mdio_reg_banks #(
  parameter int         PHY_REGS  = 8,
  parameter logic [7:0] BYTE_LAST = 8'hC6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_is_phy,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        lcl_is_phy,
  input  logic [7:0]  lcl_addr,
  input  logic        lcl_we,
  input  logic [15:0] lcl_wdata,
  output logic [15:0] lcl_rdata
);
  localparam int         BYTE_REGS = int'(BYTE_LAST) + 1;
  localparam int         PAW       = $clog2(PHY_REGS);
  localparam logic [7:0] PHY_LIM   = 8'(PHY_REGS);

  logic [15:0] phy_q  [PHY_REGS];
  logic [7:0]  byte_q [BYTE_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHY_REGS; i++)  phy_q[i]  <= '0;
      for (int i = 0; i < BYTE_REGS; i++) byte_q[i] <= '0;
    end else begin
      for (int i = 0; i < PHY_REGS; i++) begin
        if (bus_we && bus_is_phy && bus_addr == 8'(i))
          phy_q[i] <= bus_wdata;
        else if (lcl_we && lcl_is_phy && lcl_addr == 8'(i))
          phy_q[i] <= lcl_wdata;
      end
      for (int i = 0; i < BYTE_REGS; i++) begin
        if (bus_we && !bus_is_phy && bus_addr == 8'(i))
          byte_q[i] <= bus_wdata[7:0];
        else if (lcl_we && !lcl_is_phy && lcl_addr == 8'(i))
          byte_q[i] <= lcl_wdata[7:0];
      end
    end
  end

  function automatic logic [15:0] pick(input logic is_phy, input logic [7:0] a);
    logic [15:0] r;
    r = '0;
    if (is_phy) begin
      if (a < PHY_LIM) r = phy_q[a[PAW-1:0]];
    end else if (a <= BYTE_LAST) begin
      r = {8'h00, byte_q[a]};
    end
    return r;
  endfunction

  always_comb begin
    bus_rdata = pick(bus_is_phy, bus_addr);
    lcl_rdata = pick(lcl_is_phy, lcl_addr);
  end
endmodule

// File: rtl/mdio_mgmt_target.sv
module mdio_mgmt_target #(
  parameter int         PRE_LEN     = 32,
  parameter int         PHY_REGS    = 8,
  parameter logic [7:0] BYTE_LAST   = 8'hC6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic [4:0]  cfg_phy_addr,
  input  logic        lcl_phy_sel,
  input  logic [7:0]  lcl_addr,
  input  logic [15:0] lcl_wdata,
  input  logic        lcl_we,
  output logic [15:0] lcl_rdata
);
  logic        bit_stb;
  logic        bit_val;
  logic        bus_is_phy;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;

  mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .mdc_pin    (mdc),
    .mdio_pin   (mdio_i),
    .sample_stb (bit_stb),
    .sample_bit (bit_val)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .BYTE_LAST(BYTE_LAST)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_stb    (bit_stb),
    .bit_val    (bit_val),
    .own_addr   (cfg_phy_addr),
    .bus_rdata  (bus_rdata),
    .bus_is_phy (bus_is_phy),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
  );

  mdio_reg_banks #(.PHY_REGS(PHY_REGS), .BYTE_LAST(BYTE_LAST)) u_banks (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_is_phy (bus_is_phy),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .lcl_is_phy (lcl_phy_sel),
    .lcl_addr   (lcl_addr),
    .lcl_we     (lcl_we),
    .lcl_wdata  (lcl_wdata),
    .lcl_rdata  (lcl_rdata)
  );
endmodule

// File: rtl/mdio_tgt_checker.sv
module mdio_tgt_checker #(
  parameter int         PHY_REGS  = 8,
  parameter logic [7:0] BYTE_LAST = 8'hC6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        lcl_phy_sel,
  input logic [7:0]  lcl_addr,
  input logic [15:0] lcl_rdata,
  input logic        sample_stb
);
  localparam logic [7:0] PHY_LIM = 8'(PHY_REGS);

  AST_TA_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o); // R3

  AST_OUT_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({mdio_oe, mdio_o}) |-> $past(sample_stb)); // R3

  AST_PHY_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_phy_sel && lcl_addr >= PHY_LIM) |-> lcl_rdata == 16'h0000); // R11

  AST_BYTE_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcl_phy_sel && lcl_addr > BYTE_LAST) |-> lcl_rdata == 16'h0000); // R9

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lcl_phy_sel |-> lcl_rdata[15:8] == 8'h00); // R6
endmodule

bind mdio_mgmt_target mdio_tgt_checker #(
  .PHY_REGS  (PHY_REGS),
  .BYTE_LAST (BYTE_LAST)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mdio_o      (mdio_o),
  .mdio_oe     (mdio_oe),
  .lcl_phy_sel (lcl_phy_sel),
  .lcl_addr    (lcl_addr),
  .lcl_rdata   (lcl_rdata),
  .sample_stb  (bit_stb)
);

// File: tb/tb_mdio_mgmt_target.sv
module tb_mdio_mgmt_target;
  localparam logic [4:0] OWN = 5'h03;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdc = 1'b0;
  logic        mdio_i = 1'b1;
  logic        mdio_o;
  logic        mdio_oe;
  logic [4:0]  cfg_phy_addr = OWN;
  logic        lcl_phy_sel = 1'b0;
  logic [7:0]  lcl_addr = '0;
  logic [15:0] lcl_wdata = '0;
  logic        lcl_we = 1'b0;
  logic [15:0] lcl_rdata;

  int checks = 0;
  int fails  = 0;

  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] obs_q [$];

  always #2 clk = ~clk;

  mdio_mgmt_target dut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cfg_phy_addr(cfg_phy_addr),
    .lcl_phy_sel(lcl_phy_sel), .lcl_addr(lcl_addr), .lcl_wdata(lcl_wdata),
    .lcl_we(lcl_we), .lcl_rdata(lcl_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each observed read word with the oldest expectation
  always @(negedge clk) begin
    if (obs_q.size() != 0 && exp_q.size() != 0) begin
      logic [15:0] o, e;
      string t;
      o = obs_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(o == e, t, 32'(o), 32'(e));
    end
  end

  // one management bit: drive in low phase, sample outputs just before the rise
  task automatic mbit(input logic b, output logic o, output logic e);
    @(negedge clk);
    mdio_i = b;
    repeat (8) @(negedge clk);
    o = mdio_o;
    e = mdio_oe;
    mdc = 1'b1;
    repeat (8) @(negedge clk);
    mdc = 1'b0;
  endtask

  task automatic xfer(input int npre, input logic [1:0] st, input logic [1:0] op,
                      input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                      input bit rd, output logic [15:0] word, output bit any_oe,
                      output bit all_d, output bit ta_ok, output bit rel_ok);
    logic o, e, o2, e2;
    logic [13:0] hdr;
    any_oe = 0; all_d = 1; word = '0;
    hdr = {st, op, pa, ra};
    for (int i = 0; i < npre; i++) begin mbit(1'b1, o, e); any_oe |= e; end
    for (int i = 13; i >= 0; i--) begin mbit(hdr[i], o, e); any_oe |= e; end
    if (rd) begin
      mbit(1'b1, o, e); mbit(1'b1, o2, e2);
    end else begin
      mbit(1'b1, o, e); mbit(1'b0, o2, e2);
    end
    any_oe |= e | e2;
    ta_ok = !e && e2 && !o2;
    for (int i = 15; i >= 0; i--) begin
      mbit(rd ? 1'b1 : wd[i], o, e);
      word[i] = o; any_oe |= e; all_d &= e;
    end
    mbit(1'b1, o, e);
    rel_ok = !e;
    any_oe |= e;
  endtask

  task automatic do_read(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] expw, input string tag);
    logic [15:0] w; bit a, d, t, r;
    exp_q.push_back(expw); tag_q.push_back(tag);
    xfer(32, 2'b01, op, pa, ra, 16'h0, 1, w, a, d, t, r);
    obs_q.push_back(w);
    chk(t && d, {tag, " turnaround and drive"}, {30'd0, t, d}, 32'h3);
    chk(r, {tag, " released after frame"}, 32'(r), 32'h1);
  endtask

  task automatic silent_read(input int npre, input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] pa, input logic [4:0] ra, input string tag);
    logic [15:0] w; bit a, d, t, r;
    xfer(npre, st, op, pa, ra, 16'h0, 1, w, a, d, t, r);
    chk(!a, {tag, " line stays released"}, 32'(a), 32'h0);
  endtask

  task automatic do_write(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] wd);
    logic [15:0] w; bit a, d, t, r;
    xfer(32, 2'b01, op, pa, ra, wd, 0, w, a, d, t, r);
  endtask

  task automatic lcl_read(input logic sel, input logic [7:0] a, input logic [15:0] expw, input string tag);
    @(negedge clk);
    lcl_phy_sel = sel; lcl_addr = a;
    @(negedge clk);
    chk(lcl_rdata == expw, tag, 32'(lcl_rdata), 32'(expw));
  endtask

  task automatic lcl_write(input logic sel, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    lcl_phy_sel = sel; lcl_addr = a; lcl_wdata = d; lcl_we = 1'b1;
    @(negedge clk);
    lcl_we = 1'b0;
  endtask

  task automatic zero_bit();
    logic o, e;
    mbit(1'b0, o, e);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk(mdio_oe == 1'b0, "R12 released after reset", 32'(mdio_oe), 32'h0);
    lcl_read(1'b1, 8'h02, 16'h0000, "R12 port register clear");
    lcl_read(1'b0, 8'h10, 16'h0000, "R12 byte register clear");

    // R11: local port access
    lcl_write(1'b1, 8'h02, 16'hBEEF);
    lcl_read(1'b1, 8'h02, 16'hBEEF, "R11 local port write/read");
    lcl_write(1'b0, 8'h45, 16'h995A);
    lcl_read(1'b0, 8'h45, 16'h005A, "R11 local byte write keeps low byte");
    lcl_write(1'b1, 8'h09, 16'h7777);
    lcl_read(1'b1, 8'h09, 16'h0000, "R11 port index beyond bank reads zero");

    // R3: standard read
    do_read(2'b10, OWN, 5'd2, 16'hBEEF, "R3 standard read data");

    // R4: standard write then read back
    do_write(2'b01, OWN, 5'd5, 16'h1234);
    lcl_read(1'b1, 8'h05, 16'h1234, "R4 standard write stored");
    do_read(2'b10, OWN, 5'd5, 16'h1234, "R4 standard read back");

    // R5: foreign address and opcode 11
    do_write(2'b01, 5'h07, 5'd5, 16'hFFFF);
    lcl_read(1'b1, 8'h05, 16'h1234, "R5 foreign-address write ignored");
    silent_read(32, 2'b01, 2'b10, 5'h07, 5'd5, "R5 foreign-address read");
    do_write(2'b11, OWN, 5'd5, 16'h0000);
    lcl_read(1'b1, 8'h05, 16'h1234, "R5 opcode 11 ignored");

    // R6 / R10: byte read of 0x45 = {010,00101}
    do_read(2'b00, 5'b10010, 5'b00101, 16'h005A, "R6 R10 byte read");

    // R7 / R10: byte write of 0xA6 = {101,00110}, upper data byte dropped
    do_write(2'b00, 5'b00101, 5'b00110, 16'hAB77);
    lcl_read(1'b0, 8'hA6, 16'h0077, "R7 R10 byte write low half only");

    // R8: bit 3 of the port address set, same decode
    do_read(2'b00, 5'b11101, 5'b00110, 16'h0077, "R8 byte read with bit3 set");
    do_write(2'b00, 5'b01000, 5'b00011, 16'hFF11);
    lcl_read(1'b0, 8'h03, 16'h0011, "R8 byte write with bit3 set");

    // R9: boundary 0xC6 works, 0xC7 ignored
    do_write(2'b00, 5'b00110, 5'b00110, 16'h0042);
    lcl_read(1'b0, 8'hC6, 16'h0042, "R9 last byte register written");
    do_read(2'b00, 5'b10110, 5'b00110, 16'h0042, "R9 last byte register read");
    do_write(2'b00, 5'b00110, 5'b00111, 16'h00EE);
    lcl_read(1'b0, 8'hC7, 16'h0000, "R9 beyond-range local read zero");
    lcl_read(1'b0, 8'hC6, 16'h0042, "R9 beyond-range write left neighbour");
    silent_read(32, 2'b01, 2'b00, 5'b10110, 5'b00111, "R9 beyond-range byte read");

    // R1: 31 ones only (leading zero clears idle ones)
    zero_bit();
    silent_read(31, 2'b01, 2'b10, OWN, 5'd2, "R1 short preamble");
    do_read(2'b10, OWN, 5'd2, 16'hBEEF, "R1 full preamble accepted");

    // R2: bad start marker then a valid frame
    silent_read(32, 2'b00, 2'b10, OWN, 5'd2, "R2 bad start marker");
    do_read(2'b10, OWN, 5'd5, 16'h1234, "R2 recovery after abort");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule